// File: doc/BRIEF.md
# Write Bus Cycle Sequencer

This block turns a single write request into the strobe sequence of a multiplexed processor bus write. A requester presents an address, write data and a chip-select decision. The block then runs a cycle of at least four clock periods, called T1 to T4.

In T1 an address latch strobe pulses, and the address bus register is loaded when that strobe falls. The active-low chip select covers T1 through T4. The active-low write strobe is low from T2 until T4 begins. The data output enable is raised from T2 and held through T4, so data is held after the strobe rises. A ready input is sampled at the end of T3. Each low sample inserts a wait state (TW), which lengthens both the write pulse and the whole cycle.

Completion is reported with a one-cycle pulse in T4. A new request is taken in idle, or during T4 so that its T1 follows directly. The tristate data buffer outside the block is represented only by its enable.

Top module: `wr_cycle_seq`

## Requirements
- R1: While reset is held and after its release with no request, ale=0, wr_n=1, cs_n=1, den=0, done=0 and req_ready=1.
- R2: ale is high for exactly one cycle, which is the cycle after the clock edge where req_valid and req_ready are both high (T1).
- R3: bus_addr takes the accepted address at the clock edge that ends T1 and keeps its value at every other edge, so during T1 it still shows the previous address.
- R4: When the accepted req_cs is 1, cs_n is low from T1 through T4. When it is 0, cs_n stays high for the whole cycle, while all other strobes run as usual.
- R5: wr_n is low from T2 to the end of the last T3/TW cycle and high in T4. With no wait states it is low for exactly two cycles.
- R6: den is high from T2 through T4, and bus_data equals the accepted write data whenever den is high.
- R7: bus_rdy is sampled at the end of T3 and at the end of each TW. Every low sample adds one TW cycle, so the write pulse lasts 2+W cycles and the bus cycle lasts 4+W cycles for W wait states.
- R8: done is high for exactly one cycle, which is T4.
- R9: req_ready is high only in idle and in T4. A request presented in T1, T2, T3 or TW is ignored: it does not change the running cycle or bus_addr. A request presented in T4 starts its T1 in the very next cycle.
- R10: bus_rdy has no effect in idle, T1, T2 or T4. A low level there adds no wait state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Write request present |
| req_addr | input | AW | Request address |
| req_data | input | DW | Request write data |
| req_cs | input | 1 | 1 = drive the chip select for this write |
| req_ready | output | 1 | Request can be taken this cycle |
| done | output | 1 | Completion pulse in T4 |
| bus_rdy | input | 1 | Ready from the addressed device, low inserts wait states |
| ale | output | 1 | Address latch strobe, high in T1 |
| bus_addr | output | AW | Registered address bus |
| bus_data | output | DW | Write data toward the bus buffer |
| den | output | 1 | Data buffer output enable |
| cs_n | output | 1 | Active-low chip select |
| wr_n | output | 1 | Active-low write strobe |

## Verification
The bench builds the block with AW=16 and DW=8. These narrow widths make it easy to hold distinct address and data patterns, including all-ones and inverted values. The widths do not affect timing, so every state of the sequence is reachable: zero, one, two and three wait states, a low ready level held outside T3, a deselected write, a request arriving mid-cycle, and a request chained from T4.

// File: rtl/wr_cycle_seq.sv
module wr_cycle_seq #(
  parameter int AW = 20,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_data,
  input  logic          req_cs,
  output logic          req_ready,
  output logic          done,
  input  logic          bus_rdy,
  output logic          ale,
  output logic [AW-1:0] bus_addr,
  output logic [DW-1:0] bus_data,
  output logic          den,
  output logic          cs_n,
  output logic          wr_n
);
  typedef enum logic [2:0] {S_IDLE, S_T1, S_T2, S_T3, S_TW, S_T4} st_t;

  st_t           st, st_nx;
  logic [AW-1:0] addr_q;
  logic [DW-1:0] data_q;
  logic          sel_q;
  logic          take;

  assign req_ready = (st == S_IDLE) || (st == S_T4);
  assign take      = req_valid && req_ready;

  always_comb begin
    st_nx = st;
    case (st)
      S_IDLE:      if (take) st_nx = S_T1;
      S_T1:        st_nx = S_T2;
      S_T2:        st_nx = S_T3;
      S_T3, S_TW:  st_nx = bus_rdy ? S_T4 : S_TW;
      S_T4:        st_nx = take ? S_T1 : S_IDLE;
      default:     st_nx = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      addr_q   <= '0;
      data_q   <= '0;
      sel_q    <= 1'b0;
      bus_addr <= '0;
    end else begin
      st <= st_nx;
      if (take) begin
        addr_q <= req_addr;
        data_q <= req_data;
        sel_q  <= req_cs;
      end
      if (st == S_T1) bus_addr <= addr_q;
    end
  end

  assign ale      = (st == S_T1);
  assign wr_n     = !((st == S_T2) || (st == S_T3) || (st == S_TW));
  assign den      = (st == S_T2) || (st == S_T3) || (st == S_TW) || (st == S_T4);
  assign cs_n     = !(sel_q && (st != S_IDLE));
  assign done     = (st == S_T4);
  assign bus_data = data_q;
endmodule

// File: rtl/wr_cycle_seq_chk.sv
module wr_cycle_seq_chk #(
  parameter int AW = 20,
  parameter int DW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          req_valid,
  input logic          req_ready,
  input logic          done,
  input logic          bus_rdy,
  input logic          ale,
  input logic [AW-1:0] bus_addr,
  input logic          den,
  input logic          cs_n,
  input logic          wr_n
);
  assert_ale_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> ale);
  assert_ale_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ale |=> !ale);
  assert_addr_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !ale |=> $stable(bus_addr));
  assert_cs_in_cycle_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_n |-> (ale || den));
  assert_wr_ends_in_t4_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_n |=> (!wr_n || done));
  assert_wr_under_den_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_n |-> den);
  assert_wait_holds_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_n && $past(!wr_n) && !bus_rdy) |=> !wr_n);
  assert_done_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  assert_ready_in_t4_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> req_ready);
  assert_busy_no_ready_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (ale || !wr_n) |-> !req_ready);
endmodule

bind wr_cycle_seq wr_cycle_seq_chk #(.AW(AW), .DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .done(done), .bus_rdy(bus_rdy), .ale(ale), .bus_addr(bus_addr),
  .den(den), .cs_n(cs_n), .wr_n(wr_n)
);

// File: tb/wr_cycle_seq_bench.sv
module wr_cycle_seq_bench;
  localparam int AW = 16;
  localparam int DW = 8;
  localparam time PERIOD = 10ns;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_data = '0;
  logic req_cs = 1'b0;
  logic bus_rdy = 1'b1;
  logic req_ready, done, ale, den, cs_n, wr_n;
  logic [AW-1:0] bus_addr;
  logic [DW-1:0] bus_data;
  int total = 0;
  int bad = 0;
  logic [AW-1:0] prev_bus = '0;

  always #(PERIOD/2) clk = ~clk;

  wr_cycle_seq #(.AW(AW), .DW(DW)) u_wr_cycle_seq (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
    .req_data(req_data), .req_cs(req_cs), .req_ready(req_ready), .done(done),
    .bus_rdy(bus_rdy), .ale(ale), .bus_addr(bus_addr), .bus_data(bus_data),
    .den(den), .cs_n(cs_n), .wr_n(wr_n)
  );

  task automatic chk(input bit ok, input string req, input int cyc, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s cycle %0d: actual=%0h expected=%0h", req, cyc, act, exp);
    end
  endtask

  task automatic chk_idle(input string req, input int cyc);
    chk(ale == 1'b0, {req, " ale"}, cyc, ale, 0);
    chk(wr_n == 1'b1, {req, " wr_n"}, cyc, wr_n, 1);
    chk(cs_n == 1'b1, {req, " cs_n"}, cyc, cs_n, 1);
    chk(den == 1'b0, {req, " den"}, cyc, den, 0);
    chk(done == 1'b0, {req, " done"}, cyc, done, 0);
    chk(req_ready == 1'b1, {req, " req_ready"}, cyc, req_ready, 1);
  endtask

  // One write cycle; lowmask bit i drives bus_rdy low in cycle i (cycle 1 = T1).
  task automatic run_write(input logic [AW-1:0] a, input logic [DW-1:0] d, input bit cs,
                           input logic [15:0] lowmask, input bit preissued, input bit noise,
                           input bit chain, input logic [AW-1:0] a2, input logic [DW-1:0] d2);
    int w = 0;
    int last;
    while (w < 10 && lowmask[3+w]) w++;
    last = 4 + w;
    if (!preissued) begin
      chk(req_ready == 1'b1, "R9 ready before request", 0, req_ready, 1);
      req_valid = 1'b1; req_addr = a; req_data = d; req_cs = cs;
    end
    for (int i = 1; i <= last + 1; i++) begin
      @(posedge clk); @(negedge clk);
      bus_rdy = !lowmask[i];
      if (i == 1) req_valid = 1'b0;
      if (noise && i == 2) begin req_valid = 1'b1; req_addr = ~a; req_data = ~d; req_cs = !cs; end
      if (noise && i == 3) req_valid = 1'b0;
      if (i <= last) begin
        chk(ale == (i == 1), "R2 ale", i, ale, (i == 1));
        chk(wr_n == !(i >= 2 && i < last), "R5 R7 wr_n", i, wr_n, !(i >= 2 && i < last));
        chk(cs_n == !cs, "R4 cs_n", i, cs_n, !cs);
        chk(den == (i >= 2), "R6 den", i, den, (i >= 2));
        chk(done == (i == last), "R8 done", i, done, (i == last));
        chk(req_ready == (i == last), "R9 req_ready", i, req_ready, (i == last));
        if (i == 1) chk(bus_addr == prev_bus, "R3 addr before latch", i, bus_addr, prev_bus);
        else        chk(bus_addr == a, "R3 addr latched", i, bus_addr, a);
        if (den) chk(bus_data == d, "R6 data", i, bus_data, d);
        if (i == last && chain) begin
          req_valid = 1'b1; req_addr = a2; req_data = d2; req_cs = cs;
          prev_bus = a;
          return;
        end
      end else begin
        chk_idle("R9 back to idle", i);
        chk(bus_addr == a, "R3 addr held", i, bus_addr, a);
      end
    end
    bus_rdy = 1'b1;
    prev_bus = a;
  endtask

  task automatic t_reset;
    @(negedge clk);
    chk_idle("R1 in reset", 0);
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk_idle("R1 after reset", 0);
    chk(bus_addr == '0, "R1 bus_addr", 0, bus_addr, 0);
  endtask

  task automatic t_zero_wait;  run_write(16'h1234, 8'hA5, 1, 16'h0, 0, 0, 0, 0, 0); endtask
  task automatic t_one_wait;   run_write(16'hBEEF, 8'h3C, 1, 16'h0008, 0, 0, 0, 0, 0); endtask // R7
  task automatic t_three_wait; run_write(16'hFFFF, 8'hFF, 1, 16'h0038, 0, 0, 0, 0, 0); endtask // R7
  task automatic t_no_select;  run_write(16'h0F0F, 8'h81, 0, 16'h0018, 0, 0, 0, 0, 0); endtask // R4
  task automatic t_rdy_off_t3; run_write(16'h5555, 8'h11, 1, 16'h0016 | 16'h0001 | 16'h0040, 0, 0, 0, 0, 0); endtask // R10
  task automatic t_mid_request; run_write(16'h7001, 8'h42, 1, 16'h0008, 0, 1, 0, 0, 0); endtask // R9
  task automatic t_chain;
    // R9: second request in T4 starts T1 immediately
    run_write(16'hA0A0, 8'h5A, 1, 16'h0, 0, 0, 1, 16'h0B0B, 8'hC3);
    run_write(16'h0B0B, 8'hC3, 1, 16'h0008, 1, 0, 0, 0, 0);
  endtask

  initial begin
    t_reset();
    t_zero_wait();
    t_one_wait();
    t_three_wait();
    t_no_select();
    t_rdy_off_t3();
    t_mid_request();
    t_chain();
    repeat (3) @(negedge clk);
    chk_idle("R1 final idle", 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(PERIOD * 20000);
    total++;
    bad++;
    $display("FAIL watchdog: actual=hung expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule